// File: doc/BRIEF.md
# Aligned Power-of-Two Region Splitter

This block splits one address region into a run of naturally aligned power-of-two windows. Each window is suitable for one slot of an outbound address translation table. A region is given by three values: a local (processor-side) start address, a bus-side start address and a byte length. A one-cycle start pulse captures them, along with a first slot index and a prefetchable flag. From the next cycle on, the block emits one window descriptor per cycle. Each descriptor carries the slot index, both base addresses, the size exponent and a ready-made attribute word.

Each window is as large as possible. It is limited by the largest power of two that fits in the remaining length, and by the common alignment of the two current addresses. After a window is emitted, both addresses and the remaining length move on by the window size. The run stops in one of three ways: the length is used up, the table runs out of slots, or a window would fall below the minimum translation granule of 4 KiB. A one-cycle done pulse then presents a status code and the number of slots consumed. Programming the table itself is left to the consumer of the descriptors.

Top module: `region_window_splitter`

## Requirements
- R1: During and right after reset, `win_valid_o` and `done_o` are low, `used_o` is 0 and `status_o` is 0 (ok).
- R2: The exponent of every window is the smaller of two values: floor(log2(remaining length)), and the index of the lowest set bit of (local address OR bus address). When both addresses are zero, only the length limit applies.
- R3: Each window base is aligned to its size. Each following window starts where the previous one ended, on both address sides, and the windows' sizes add up to the region length on success.
- R4: Slot indices start at `first_slot_i` and rise by one per emitted window.
- R5: The first descriptor appears in the cycle after the start pulse is captured, and further descriptors follow on consecutive cycles with no gap.
- R6: `done_o` pulses for one cycle, in the cycle after the last descriptor, and never together with `win_valid_o`. At that pulse `used_o` equals the number of descriptors emitted in the run; it holds until the next done.
- R7: If a window is still needed but its slot index is 5 or more, the run stops without emitting it. Status is 1 (slots exhausted) and `used_o` counts only the windows already emitted. This check takes priority over R11.
- R8: The attribute word has bit 31 set (enable), bits [19:16] = 4'h4 (memory read), bits [15:12] = 4'h4 (memory write) and bits [5:0] = exponent minus 1. All other bits except bit 28 are zero.
- R9: Attribute bit 28 (relaxed ordering) is set on every window of a run exactly when `prefetch_i` was high at the start pulse.
- R10: A zero-length region emits no descriptor. Its done pulse comes one cycle after the start is captured, with status 0 and `used_o` = 0.
- R11: If the next window's exponent would be below 12, the run stops without emitting it, with status 2 (alignment error).
- R12: A start pulse that arrives while a run is in progress is ignored, and the run completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture the region and begin a run (ignored while busy) |
| first_slot_i | input | 3 | Slot index of the first window |
| loc_addr_i | input | 64 | Local start address of the region |
| bus_addr_i | input | 64 | Bus-side start address of the region |
| len_i | input | 64 | Region length in bytes |
| prefetch_i | input | 1 | Region is prefetchable; set relaxed ordering |
| win_valid_o | output | 1 | Descriptor valid this cycle |
| win_slot_o | output | 3 | Slot index of the descriptor |
| win_loc_o | output | 64 | Local base of the window |
| win_bus_o | output | 64 | Bus base of the window |
| win_exp_o | output | 6 | Size exponent (window is 2^exp bytes) |
| win_attr_o | output | 32 | Attribute word for the slot |
| done_o | output | 1 | Run finished (one-cycle pulse) |
| status_o | output | 2 | 0 ok, 1 slots exhausted, 2 alignment error |
| used_o | output | 3 | Slots consumed by the last run |

## Verification
The embedded assertions check several properties on every cycle. No emitted window is below the 4 KiB granule or in an out-of-range slot. Window bases are aligned to their size. Consecutive windows are contiguous and take consecutive slots. The size code matches the exponent, and done never coincides with a descriptor. Other behaviours only directed scenarios can show: the exact exponent chosen at each step, when and why a run stops, the priority of slot exhaustion over misalignment, the relaxed-ordering flag following the start pulse, and a start being ignored mid-run.

// File: rtl/rws_pkg.sv
package rws_pkg;
  typedef enum logic [1:0] {
    RWS_OK     = 2'd0,
    RWS_NOSLOT = 2'd1,
    RWS_ALIGN  = 2'd2
  } rws_status_e;

  typedef enum logic {
    RWS_IDLE = 1'b0,
    RWS_RUN  = 1'b1
  } rws_state_e;

  localparam int ATTR_W      = 32;
  localparam int ATTR_EN_BIT = 31;
  localparam int ATTR_RO_BIT = 28;
  localparam int ATTR_RD_LSB = 16;
  localparam int ATTR_WR_LSB = 12;
  localparam int ATTR_CODE_W = 6;
  localparam logic [3:0] ATTR_MEM_RW = 4'h4;
endpackage

// File: rtl/rws_lowbit.sv
// Index of the lowest set bit; none_o when the vector is zero.
module rws_lowbit #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          none_o
);
  logic [W-1:0] below;
  logic [W-1:0] hot;

  assign below[0] = 1'b0;
  for (genvar gi = 1; gi < W; gi++) begin : g_chain
    assign below[gi] = below[gi-1] | vec_i[gi-1];
  end
  assign hot    = vec_i & ~below;
  assign none_o = ~|vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (hot[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/rws_highbit.sv
// Index of the highest set bit (floor log2); zero for a zero vector.
module rws_highbit #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  logic [W-1:0] above;
  logic [W-1:0] hot;

  assign above[W-1] = 1'b0;
  for (genvar gi = 0; gi < W-1; gi++) begin : g_chain
    assign above[gi] = above[gi+1] | vec_i[gi+1];
  end
  assign hot = vec_i & ~above;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (hot[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/rws_step.sv
// One split step: largest aligned window fitting the remaining length.
module rws_step #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  loc_i,
  input  logic [W-1:0]  bus_i,
  input  logic [W-1:0]  rem_i,
  output logic [IW-1:0] exp_o,
  output logic [W-1:0]  size_o
);
  logic [IW-1:0] fit_exp;
  logic [IW-1:0] algn_exp;
  logic          algn_none;

  rws_highbit #(.W(W), .IW(IW)) u_fit (
    .vec_i (rem_i),
    .idx_o (fit_exp)
  );

  rws_lowbit #(.W(W), .IW(IW)) u_algn (
    .vec_i  (loc_i | bus_i),
    .idx_o  (algn_exp),
    .none_o (algn_none)
  );

  always_comb begin
    if (algn_none || (fit_exp < algn_exp)) exp_o = fit_exp;
    else                                   exp_o = algn_exp;
    size_o = {{(W-1){1'b0}}, 1'b1} << exp_o;
  end
endmodule

// File: rtl/region_window_splitter.sv
module region_window_splitter
  import rws_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int NUM_SLOTS = 5,
  parameter int MIN_EXP   = 12,
  parameter int SLOT_W    = $clog2(NUM_SLOTS + 1),
  parameter int EXP_W     = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] first_slot_i,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic              prefetch_i,
  output logic              win_valid_o,
  output logic [SLOT_W-1:0] win_slot_o,
  output logic [ADDR_W-1:0] win_loc_o,
  output logic [ADDR_W-1:0] win_bus_o,
  output logic [EXP_W-1:0]  win_exp_o,
  output logic [31:0]       win_attr_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [SLOT_W-1:0] used_o
);
  localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(NUM_SLOTS);
  localparam logic [EXP_W-1:0]  EXP_LIM  = EXP_W'(MIN_EXP);

  // Working state
  rws_state_e        st_q, st_d;
  logic [ADDR_W-1:0] loc_q, loc_d, bus_q, bus_d, rem_q, rem_d;
  logic [SLOT_W-1:0] slot_q, slot_d, cnt_q, cnt_d;
  logic              pf_q, pf_d;
  logic              work_en;

  // Output registers
  logic              vld_d, done_d;
  logic [SLOT_W-1:0] oslot_d, used_d;
  logic [ADDR_W-1:0] oloc_d, obus_d;
  logic [EXP_W-1:0]  oexp_d;
  logic [31:0]       attr_d;
  rws_status_e       stat_q, stat_d;
  logic              win_en, fin_en;

  // Step datapath
  logic [EXP_W-1:0]  step_exp;
  logic [ADDR_W-1:0] step_size;

  rws_step #(.W(ADDR_W), .IW(EXP_W)) u_step (
    .loc_i  (loc_q),
    .bus_i  (bus_q),
    .rem_i  (rem_q),
    .exp_o  (step_exp),
    .size_o (step_size)
  );

  always_comb begin
    attr_d = '0;
    attr_d[ATTR_EN_BIT]                  = 1'b1;
    attr_d[ATTR_RO_BIT]                  = pf_q;
    attr_d[ATTR_RD_LSB +: 4]             = ATTR_MEM_RW;
    attr_d[ATTR_WR_LSB +: 4]             = ATTR_MEM_RW;
    attr_d[ATTR_CODE_W-1:0]              = ATTR_CODE_W'(step_exp - EXP_W'(1));
  end

  // Next-state process
  always_comb begin
    st_d    = st_q;
    loc_d   = loc_q;
    bus_d   = bus_q;
    rem_d   = rem_q;
    slot_d  = slot_q;
    cnt_d   = cnt_q;
    pf_d    = pf_q;
    work_en = 1'b0;
    vld_d   = 1'b0;
    done_d  = 1'b0;
    win_en  = 1'b0;
    fin_en  = 1'b0;
    oslot_d = slot_q;
    oloc_d  = loc_q;
    obus_d  = bus_q;
    oexp_d  = step_exp;
    stat_d  = stat_q;
    used_d  = cnt_q;
    unique case (st_q)
      RWS_IDLE: begin
        if (start_i) begin
          work_en = 1'b1;
          st_d    = RWS_RUN;
          loc_d   = loc_addr_i;
          bus_d   = bus_addr_i;
          rem_d   = len_i;
          slot_d  = first_slot_i;
          cnt_d   = '0;
          pf_d    = prefetch_i;
        end
      end
      RWS_RUN: begin
        if (rem_q == '0) begin
          st_d   = RWS_IDLE;
          done_d = 1'b1;
          fin_en = 1'b1;
          stat_d = RWS_OK;
        end else if (slot_q >= SLOT_LIM) begin
          st_d   = RWS_IDLE;
          done_d = 1'b1;
          fin_en = 1'b1;
          stat_d = RWS_NOSLOT;
        end else if (step_exp < EXP_LIM) begin
          st_d   = RWS_IDLE;
          done_d = 1'b1;
          fin_en = 1'b1;
          stat_d = RWS_ALIGN;
        end else begin
          work_en = 1'b1;
          vld_d   = 1'b1;
          win_en  = 1'b1;
          loc_d   = loc_q + step_size;
          bus_d   = bus_q + step_size;
          rem_d   = rem_q - step_size;
          slot_d  = slot_q + SLOT_W'(1);
          cnt_d   = cnt_q + SLOT_W'(1);
        end
      end
      default: st_d = RWS_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= RWS_IDLE;
      loc_q       <= '0;
      bus_q       <= '0;
      rem_q       <= '0;
      slot_q      <= '0;
      cnt_q       <= '0;
      pf_q        <= 1'b0;
      win_valid_o <= 1'b0;
      done_o      <= 1'b0;
      win_slot_o  <= '0;
      win_loc_o   <= '0;
      win_bus_o   <= '0;
      win_exp_o   <= '0;
      win_attr_o  <= '0;
      stat_q      <= RWS_OK;
      used_o      <= '0;
    end else begin
      st_q        <= st_d;
      win_valid_o <= vld_d;
      done_o      <= done_d;
      if (work_en) begin
        loc_q  <= loc_d;
        bus_q  <= bus_d;
        rem_q  <= rem_d;
        slot_q <= slot_d;
        cnt_q  <= cnt_d;
        pf_q   <= pf_d;
      end
      if (win_en) begin
        win_slot_o <= oslot_d;
        win_loc_o  <= oloc_d;
        win_bus_o  <= obus_d;
        win_exp_o  <= oexp_d;
        win_attr_o <= attr_d;
      end
      if (fin_en) begin
        stat_q <= stat_d;
        used_o <= used_d;
      end
    end
  end

  assign status_o = stat_q;

  // R11
  granule_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (win_exp_o >= EXP_LIM));

  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (win_slot_o < SLOT_LIM));

  // R3
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (((win_loc_o | win_bus_o) &
      (({{(ADDR_W-1){1'b0}}, 1'b1} << win_exp_o) - 1'b1)) == '0));

  // R3
  contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid_o && $past(win_valid_o)) |->
      (win_loc_o == $past(win_loc_o) + ({{(ADDR_W-1){1'b0}}, 1'b1} << $past(win_exp_o))));

  // R4
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid_o && $past(win_valid_o)) |-> (win_slot_o == $past(win_slot_o) + SLOT_W'(1)));

  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && win_valid_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (win_attr_o[ATTR_CODE_W-1:0] == ATTR_CODE_W'(win_exp_o - EXP_W'(1))));
endmodule

// File: tb/region_window_splitter_bench.sv
module region_window_splitter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  first_slot_i;
  logic [63:0] loc_addr_i, bus_addr_i, len_i;
  logic        prefetch_i;
  logic        win_valid_o;
  logic [2:0]  win_slot_o;
  logic [63:0] win_loc_o, win_bus_o;
  logic [5:0]  win_exp_o;
  logic [31:0] win_attr_o;
  logic        done_o;
  logic [1:0]  status_o;
  logic [2:0]  used_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  region_window_splitter u_region_window_splitter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_slot_i(first_slot_i),
    .loc_addr_i(loc_addr_i), .bus_addr_i(bus_addr_i), .len_i(len_i),
    .prefetch_i(prefetch_i), .win_valid_o(win_valid_o), .win_slot_o(win_slot_o),
    .win_loc_o(win_loc_o), .win_bus_o(win_bus_o), .win_exp_o(win_exp_o),
    .win_attr_o(win_attr_o), .done_o(done_o), .status_o(status_o), .used_o(used_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int flog2(logic [63:0] v);
    int r = 0;
    for (int i = 0; i < 64; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int lowbit(logic [63:0] v);
    int r = 64;
    for (int i = 63; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [31:0] attr_of(int e, bit pf);
    return 32'h8004_4000 | (pf ? 32'h1000_0000 : 32'h0) | 32'(e - 1);
  endfunction

  // Drives one run and follows it with a requirement model every cycle.
  task automatic run_case(input string tag, input logic [63:0] loc, input logic [63:0] bus,
                          input logic [63:0] len, input logic [2:0] first, input bit pf,
                          input int n_win, input logic [1:0] st, input bit poke);
    logic [63:0] m_loc = loc, m_bus = bus, m_rem = len;
    int m_slot = first;
    int emitted = 0;
    int e;
    bit over = 0;
    @(negedge clk);
    start_i = 1; loc_addr_i = loc; bus_addr_i = bus; len_i = len;
    first_slot_i = first; prefetch_i = pf;
    @(negedge clk);
    start_i = 0; loc_addr_i = '1; len_i = 0; prefetch_i = ~pf; first_slot_i = 0;
    for (int cyc = 0; cyc < 12 && !over; cyc++) begin
      @(negedge clk);
      if (poke && cyc == 0) start_i = 1;          // R12 start while busy
      if (poke && cyc == 1) start_i = 0;
      if (m_rem == 0 || m_slot >= 5) e = 99;
      else begin
        e = flog2(m_rem);
        if (lowbit(m_loc | m_bus) < e) e = lowbit(m_loc | m_bus);
      end
      if (m_rem != 0 && m_slot < 5 && e >= 12) begin
        // R2 R3 R4 R5 R8 R9
        chk(win_valid_o && !done_o, {tag, " R5"}, "valid", win_valid_o, 1);
        chk(win_exp_o == 6'(e), {tag, " R2"}, "exp", win_exp_o, e);
        chk(win_loc_o == m_loc && win_bus_o == m_bus, {tag, " R3"}, "base", win_loc_o, m_loc);
        chk(win_slot_o == 3'(m_slot), {tag, " R4"}, "slot", win_slot_o, m_slot);
        chk(win_attr_o == attr_of(e, pf), {tag, " R8 R9"}, "attr", win_attr_o, attr_of(e, pf));
        m_loc += 64'd1 << e; m_bus += 64'd1 << e; m_rem -= 64'd1 << e;
        m_slot++; emitted++;
      end else begin
        // R6 R7 R10 R11
        chk(done_o && !win_valid_o, {tag, " R6"}, "done", done_o, 1);
        chk(status_o == st, {tag, " R7 R11"}, "status", status_o, st);
        chk(used_o == 3'(n_win), {tag, " R6"}, "used", used_o, n_win);
        chk(emitted == n_win, {tag, " R6"}, "windows", emitted, n_win);
        over = 1;
      end
    end
    chk(over == 1, {tag, " R6"}, "finished", over, 1);
    @(negedge clk);
    chk(!done_o && !win_valid_o, {tag, " R6"}, "quiet after done", done_o, 0);
  endtask

  task automatic t_reset;
    rst_n = 0; start_i = 0; first_slot_i = 0; loc_addr_i = 0; bus_addr_i = 0;
    len_i = 0; prefetch_i = 0;
    repeat (3) @(negedge clk);
    chk(!win_valid_o && !done_o, "R1", "flags in reset", {win_valid_o, done_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(used_o == 0 && status_o == 0, "R1", "status after reset", {used_o, status_o}, 0);
    chk(!win_valid_o && !done_o, "R1", "flags after reset", {win_valid_o, done_o}, 0);
  endtask

  initial begin
    t_reset();
    run_case("single aligned", 64'h8000_0000, 64'h8000_0000, 64'h1000_0000, 3'd1, 0, 1, 2'd0, 0);
    run_case("three pieces",   64'h0001_0000, 64'hC001_0000, 64'h7000, 3'd1, 0, 3, 2'd0, 0);
    run_case("prefetch high",  64'h4000_0000, 64'h2_0000_0000, 64'h6000_0000, 3'd0, 1, 2, 2'd0, 0);
    run_case("zero address",   64'h0, 64'h0, 64'h3000, 3'd0, 1, 2, 2'd0, 0);
    run_case("R10 zero len",   64'h1000, 64'h2000, 64'h0, 3'd2, 0, 0, 2'd0, 0);
    run_case("R7 exhaust",     64'h0001_0000, 64'h0001_0000, 64'h7000, 3'd3, 0, 2, 2'd1, 0);
    run_case("R7 first5",      64'h0, 64'h0, 64'h1000, 3'd5, 0, 0, 2'd1, 0);
    run_case("R11 misalign",   64'h800, 64'h0, 64'h4000, 3'd1, 0, 0, 2'd2, 0);
    run_case("R11 short tail", 64'h1_0000, 64'h1_0000, 64'h1800, 3'd1, 0, 1, 2'd2, 0);
    run_case("R7 over R11",    64'h1_0000, 64'h1_0000, 64'h1800, 3'd4, 1, 1, 2'd1, 0);
    run_case("R12 busy start", 64'h0001_0000, 64'hC001_0000, 64'h7000, 3'd0, 1, 3, 2'd0, 1);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule